// File: doc/BRIEF.md
# Gated Edge Tally

This block counts transitions of one digital input that has already been brought into the clock domain. A host controls it with write strobes that carry a 4-bit control word. Two bits of the word choose which edges are counted: rising, falling, or both. Two more bits are one-shot commands. One clears the tally. The other emits the tally once as an output event.

A measurement window is opened by a write that enables the chosen edges and clears the tally. A later write disables both edge kinds and requests a report. Each window therefore produces a single event instead of one event per edge, and several windows can follow one another freely.

The tally saturates at 2^(W-1)-1. A report carrying that value tells the host that edges may have been lost.

Internally, a four-state sensitivity machine holds the edge selection. The states are SENSE_OFF, SENSE_RISE, SENSE_FALL and SENSE_BOTH, encoded as control bits [1:0] = 00, 01, 10 and 11.
- The only transition is "reselect". On any write, the machine jumps to the state named by bits [1:0].
- When there is no write, it holds its state.

Top module: `gated_edge_tally`

## Requirements
- R1: Control bit 0 enables counting of rising edges of `sig_in`. An edge is a change between the value sampled at one clock edge and the value sampled at the previous clock edge, so a level held high counts once. Enables written at a clock edge apply from the following clock edge onward.
- R2: Control bit 1 enables counting of falling edges. With bits 0 and 1 both set, every transition is counted.
- R3: A write with control bit 2 set makes `evt_valid` high in the next cycle. In that cycle, `evt_count` carries the tally as it stood before the clock edge that accepted the write.
- R4: `evt_valid` is high for exactly one cycle per report request and is otherwise low. `evt_count` changes only when a report is emitted and holds its value until the next report.
- R5: A write with control bit 3 set clears the tally at the accepting clock edge. If an edge counted under the enables already in effect arrives at that same clock edge, the tally becomes 1 instead of 0.
- R6: The tally never exceeds 2^(W-1)-1 (W defaults to 31). Further counted edges leave it at that value.
- R7: When bits 2 and 3 are set in the same write, the report carries the value from before the clear, and the tally is zero afterwards.
- R8: Edge enables persist until the next write. A write with bits 2 and 3 clear emits no event and leaves the tally as it is. The one-shot bits act only once per write.
- R9: After reset, the tally is 0, both edge kinds are disabled, `evt_valid` is low and `evt_count` is 0.
- R10: Gate windows requested one after another each yield exactly one event, emitted in the order the windows were closed, each carrying its own window's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_word | input | 4 | Control word. [0] rising enable, [1] falling enable, [2] report request, [3] clear request |
| sig_in | input | 1 | Synchronized input whose transitions are counted |
| evt_valid | output | 1 | One-cycle report strobe |
| evt_count | output | W | Reported tally, held between reports |

## Verification
The properties assume `cfg_word` is meaningful only while `cfg_we` is high. They also assume `sig_in` is a clean synchronous signal that changes at most once per clock cycle, so every change is seen as exactly one edge.

The directed stimulus keeps within these assumptions. It drives `cfg_we`, `cfg_word` and `sig_in` only on falling clock edges, holds each write strobe for one cycle, and holds each input level for at least one cycle. It also places an input edge on the same clock edge as a clear on purpose, to exercise the load-one rule.

// File: rtl/gated_edge_tally_pkg.sv
package gated_edge_tally_pkg;

    // Sensitivity state; encoding equals control bits [1:0]
    typedef enum logic [1:0] {
        SENSE_OFF  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_t;

    localparam int CTL_BIT_REPORT = 2;
    localparam int CTL_BIT_CLEAR  = 3;
    localparam int CTL_WIDTH      = 4;

endpackage

// File: rtl/edge_probe.sv
module edge_probe (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
    assign fall_o = ~level_i & level_q;
endmodule

// File: rtl/tally_sat.sv
module tally_sat #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] tally_o
);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] tally_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (clr_i) begin
            tally_q <= inc_i ? ONE : '0;
        end else if (inc_i && (tally_q != SAT_MAX)) begin
            tally_q <= tally_q + ONE;
        end
    end

    assign tally_o = tally_q;
endmodule

// File: rtl/gated_edge_tally.sv
module gated_edge_tally
    import gated_edge_tally_pkg::*;
#(
    parameter int W = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CTL_WIDTH-1:0] cfg_word,
    input  logic                 sig_in,
    output logic                 evt_valid,
    output logic [W-1:0]         evt_count
);
    sense_t       sense_q, sense_d;
    logic         rise, fall, hit;
    logic         clr_req, rep_req;
    logic [W-1:0] tally_q;

    edge_probe u_probe (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sig_in),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sense_q <= SENSE_OFF;
        else        sense_q <= sense_d;
    end

    // Reselect transition on every write
    always_comb begin
        sense_d = cfg_we ? sense_t'(cfg_word[1:0]) : sense_q;
    end

    // Outputs of the machine: which edges count
    always_comb begin
        hit = 1'b0;
        unique case (sense_q)
            SENSE_OFF:  hit = 1'b0;
            SENSE_RISE: hit = rise;
            SENSE_FALL: hit = fall;
            SENSE_BOTH: hit = rise | fall;
        endcase
    end

    assign clr_req = cfg_we & cfg_word[CTL_BIT_CLEAR];
    assign rep_req = cfg_we & cfg_word[CTL_BIT_REPORT];

    tally_sat #(.W(W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_req),
        .inc_i   (hit),
        .tally_o (tally_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_count <= '0;
        end else begin
            evt_valid <= rep_req;
            if (rep_req) evt_count <= tally_q;
        end
    end
endmodule

// File: rtl/gated_edge_tally_chk.sv
module gated_edge_tally_chk #(
    parameter int W = 31
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_we,
    input logic [3:0]   cfg_word,
    input logic         evt_valid,
    input logic [W-1:0] evt_count,
    input logic [W-1:0] tally
);
    localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};

    AST_REPORT_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_word[2]) |=> evt_valid); // R3
    AST_REPORT_VALUE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_word[2]) |=> (evt_count == $past(tally))); // R7
    AST_NO_SPURIOUS_EVT: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_we && cfg_word[2]) |=> !evt_valid); // R4
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(evt_count) |-> evt_valid); // R4
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_word[3]) |=> (tally <= UNIT)); // R5
    AST_SAT_CEILING: assert property (@(posedge clk) disable iff (!rst_n) (tally <= TOP)); // R6
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_we && cfg_word[3]) |=> ((tally == $past(tally)) || (tally == $past(tally) + UNIT))); // R8
endmodule

bind gated_edge_tally gated_edge_tally_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_word  (cfg_word),
    .evt_valid (evt_valid),
    .evt_count (evt_count),
    .tally     (tally_q)
);

// File: tb/sim_gated_edge_tally.sv
module sim_gated_edge_tally;
    localparam int W  = 31;
    localparam int WS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_word = 4'h0;
    logic          sig_in = 1'b0;
    logic          evt_valid, evt_valid_s;
    logic [W-1:0]  evt_count;
    logic [WS-1:0] evt_count_s;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    logic         last_valid;
    logic [W-1:0] last_count;

    always #4 clk = ~clk;

    gated_edge_tally #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .sig_in(sig_in), .evt_valid(evt_valid), .evt_count(evt_count)
    );

    gated_edge_tally #(.W(WS)) u_small (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .sig_in(sig_in), .evt_valid(evt_valid_s), .evt_count(evt_count_s)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the accepting edge
    task automatic wr(input logic [3:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0; cfg_word = 4'h0;
        last_valid = evt_valid;
        last_count = evt_count;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sig_in = 1'b1;
            @(negedge clk) sig_in = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 valid", evt_valid, 0);
        chk("R9 count", evt_count, 0);
        pulses(2);
        wr(4'b0100);
        chk("R9 edges disabled after reset", last_count, 0);
    endtask

    task automatic t_rise_only();
        wr(4'b1001);
        pulses(3);
        @(negedge clk) sig_in = 1'b1;
        repeat (4) @(negedge clk);
        sig_in = 1'b0;
        @(negedge clk);
        wr(4'b0100);
        chk("R3 valid", last_valid, 1);
        chk("R1 rising only, held level once", last_count, 4);
    endtask

    task automatic t_windows();
        logic [W-1:0] got [3];
        wr(4'b1001); pulses(3); wr(4'b0100); got[0] = last_count;
        wr(4'b1010); pulses(5); wr(4'b0100); got[1] = last_count;
        wr(4'b1011); pulses(2); wr(4'b0100); got[2] = last_count;
        chk("R10 first window", got[0], 3);
        chk("R2 falling window", got[1], 5);
        chk("R2 both edges window", got[2], 4);
    endtask

    task automatic t_sticky();
        wr(4'b1001);
        pulses(2);
        wr(4'b0000);
        chk("R8 plain write no event", last_valid, 0);
        pulses(3);
        wr(4'b0100);
        chk("R8 count frozen after disable", last_count, 2);
        @(negedge clk);
        chk("R4 valid one cycle", evt_valid, 0);
        chk("R4 count held", evt_count, 2);
    endtask

    task automatic t_clear_edge();
        wr(4'b1001);
        pulses(2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = 4'b1001; sig_in = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_word = 4'h0;
        @(negedge clk);
        wr(4'b0100);
        sig_in = 1'b0;
        @(negedge clk);
        chk("R5 clear with coincident edge loads 1", last_count, 1);
    endtask

    task automatic t_report_clear();
        wr(4'b1001);
        pulses(4);
        wr(4'b1100);
        chk("R7 report before clear", last_count, 4);
        wr(4'b0100);
        chk("R7 cleared afterwards", last_count, 0);
        wr(4'b1011);
        wr(4'b0100);
        chk("R5 clear to zero", last_count, 0);
    endtask

    task automatic t_saturate();
        wr(4'b1001);
        pulses(10);
        wr(4'b0100);
        chk("R6 wide counter", last_count, 10);
        chk("R6 small counter saturates", evt_count_s, 7);
        chk("R6 small valid", evt_valid_s, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_only();
        t_windows();
        t_sticky();
        t_clear_edge();
        t_report_clear();
        t_saturate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule